// File: doc/BRIEF.md
# Programmable Serial Audio Frame Transmitter

This block drives a serial audio link as the clock master. It divides the system clock into a bit clock and builds each frame from a run-time frame description: the number of words, the width of word zero, the width of every later word, the length of the frame sync, the frame sync polarity, whether the frame sync leads the frame by one bit, the bit order and the bit clock polarity. A single datapath can therefore produce a two-word stereo frame with sync that changes on the channel boundary, a short one-bit sync pulse for time-slot streams, or a thirteen-slot frame with a 16-bit tag word followed by 20-bit slots.

Samples arrive as 32-bit words on a valid/ready port. The block takes one sample each time a word begins. If no sample is offered, it sends zeros and records an underrun. Three sticky flags report word starts, underruns and sync errors, and each is cleared by a one-cycle clear pulse. A sync error is recorded when a word boundary finds the word counter already past the programmed last word, which happens when the frame size is reduced during a frame. The frame then restarts. A soft reset stops the engine and clears the flags without affecting the configuration.

Top module: `audfrm_tx`

## Requirements
- R1: After reset, and while `en` is low, `bclk` rests at the level of `cfg_bclk_inv`, `fsync` rests at the level of `cfg_fs_low`, and `sdata`, `word_start`, `s_ready` and all three flags are 0.
- R2: With `en` high, each bit lasts 2*(`cfg_div_m1`+1) clock cycles. `bclk` equals `cfg_bclk_inv` for the first `cfg_div_m1`+1 cycles of a bit and the inverse for the rest. `sdata` changes only in the first cycle of a bit.
- R3: A frame holds `cfg_frame_m1`+1 words. Word 0 is `cfg_first_m1`+1 bits long and each later word is `cfg_other_m1`+1 bits long. Frames repeat back to back, and the first bit appears in the clock cycle after the edge that samples `en` high.
- R4: When `cfg_msb_first`=1, a word of width W sends sample bits W-1 down to 0. When it is 0, the word sends bits 0 up to W-1. Sample bits at positions W and above never reach `sdata`.
- R5: The frame sync is active for `cfg_sync_m1`+1 bit periods counted from bit 0 of word 0. With `cfg_fs_early`=1 the active window starts one bit earlier, on the last bit of the previous frame (the first frame after enable has no such bit). The active level on `fsync` is 1 when `cfg_fs_low`=0 and 0 when `cfg_fs_low`=1.
- R6: `s_ready` is high for exactly one cycle per word, in the cycle before that word's first bit. The sample present in that cycle is the one sent, so each frame consumes `cfg_frame_m1`+1 samples.
- R7: If `s_valid` is low when a word is loaded, that word is sent as all zeros and `flag_underrun` is set. The flag stays set until a `clr_underrun` pulse.
- R8: `word_start` is high for the first clock cycle of every word. `flag_word_start` is set at each word start and stays set until a `clr_word_start` pulse.
- R9: If a word boundary finds the current word index greater than `cfg_frame_m1`, `flag_sync_err` is set and the next word is word 0. The flag stays set until a `clr_sync_err` pulse and stays 0 during frames whose size is not reduced.
- R10: `soft_rst` returns the engine to the idle levels of R1 and clears all flags in the cycle after it is sampled. A later enable starts again at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Engine and flag reset; configuration is unaffected |
| en | input | 1 | Run enable |
| cfg_bclk_inv | input | 1 | Bit clock idle/first-half level |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_fs_early | input | 1 | Frame sync leads by one bit |
| cfg_fs_low | input | 1 | Frame sync active low |
| cfg_frame_m1 | input | 4 | Words per frame minus one |
| cfg_sync_m1 | input | 5 | Sync length in bits minus one |
| cfg_first_m1 | input | 5 | Word 0 width minus one |
| cfg_other_m1 | input | 5 | Width of words 1..N minus one |
| cfg_div_m1 | input | DIV_W | Half bit period in clocks minus one |
| s_valid | input | 1 | Sample offered |
| s_data | input | 32 | Sample word |
| s_ready | output | 1 | Sample taken this cycle |
| clr_word_start | input | 1 | Clear word-start flag |
| clr_sync_err | input | 1 | Clear sync-error flag |
| clr_underrun | input | 1 | Clear underrun flag |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| word_start | output | 1 | One-cycle pulse at each word start |
| flag_word_start | output | 1 | Sticky word-start flag |
| flag_sync_err | output | 1 | Sticky sync-error flag |
| flag_underrun | output | 1 | Sticky underrun flag |

## Verification
The frame engine runs with directed formats: a stereo frame with early active-low sync, a left-justified frame with late active-high sync, early and late one-bit sync pulses, and a thirteen-slot frame with unequal slot widths. It also runs with randomly drawn word counts, widths, sync lengths, polarities and divider values. Each bit is compared with a bench model. The directed formats separate the early and late sync placements and the effect of polarity. The random formats exercise unequal first and later widths and sync windows that cross word boundaries. A least-significant-bit-first case with random upper bits shows that bits above the word width are ignored. An unfed run and a mid-frame frame-size reduction exercise the underrun and sync-error paths, and a soft reset during a run exercises the return to idle.

// File: rtl/audfrm_pkg.sv
package audfrm_pkg;

    localparam int SMP_W  = 32;
    localparam int BIT_IW = $clog2(SMP_W);
    localparam int WRD_IW = 4;
    localparam int POS_W  = BIT_IW + WRD_IW;

    // Run-time frame description
    typedef struct packed {
        logic              bclk_inv;
        logic              msb_first;
        logic              fs_early;
        logic              fs_low;
        logic [WRD_IW-1:0] frame_m1;
        logic [BIT_IW-1:0] sync_m1;
        logic [BIT_IW-1:0] first_m1;
        logic [BIT_IW-1:0] other_m1;
    } fmt_t;

    // Position of the bit currently on the line
    typedef struct packed {
        logic [WRD_IW-1:0] word;
        logic [BIT_IW-1:0] bit_i;
        logic [BIT_IW-1:0] wid_m1;
        logic [POS_W-1:0]  pos;
    } cur_t;

    function automatic logic [BIT_IW-1:0] bit_sel(
        input logic              msb,
        input logic [BIT_IW-1:0] wid_m1,
        input logic [BIT_IW-1:0] bit_i
    );
        return msb ? (wid_m1 - bit_i) : bit_i;
    endfunction

    function automatic logic fs_active(input fmt_t f, input cur_t c);
        logic last;
        last = (c.word == f.frame_m1) && (c.bit_i == c.wid_m1);
        if (f.fs_early)
            return last || (c.pos < POS_W'(f.sync_m1));
        else
            return c.pos <= POS_W'(f.sync_m1);
    endfunction

endpackage

// File: rtl/audfrm_clkdiv.sv
module audfrm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DIV_W-1:0] div_m1,
    output logic             ph,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !go) begin
            cnt <= '0;
            ph  <= 1'b0;
        end else if (cnt == div_m1) begin
            cnt <= '0;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = go && ph && (cnt == div_m1);

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (go && cnt != div_m1) |=> (ph == $past(ph))); // R2

endmodule

// File: rtl/audfrm_seq.sv
module audfrm_seq
    import audfrm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             en,
    input  fmt_t             fmt,
    input  logic             tick,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_data,
    output logic             running,
    output cur_t             cur,
    output logic [SMP_W-1:0] wdata,
    output logic             s_ready,
    output logic             new_word,
    output logic             udr_set,
    output logic             se_set
);
    logic              start, adv, wrap, over;
    logic [WRD_IW-1:0] next_word;

    always_comb begin
        start     = en && !running;
        adv       = en && running && tick;
        wrap      = (cur.bit_i == cur.wid_m1);
        new_word  = start || (adv && wrap);
        over      = running && (cur.word > fmt.frame_m1);
        next_word = (!running || cur.word >= fmt.frame_m1) ? '0 : cur.word + 1'b1;
        se_set    = adv && wrap && over;
        s_ready   = new_word;
        udr_set   = new_word && !s_valid;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            running <= 1'b0;
            cur     <= '0;
            wdata   <= '0;
        end else if (!en) begin
            running <= 1'b0;
        end else if (new_word) begin
            running    <= 1'b1;
            cur.word   <= next_word;
            cur.bit_i  <= '0;
            cur.wid_m1 <= (next_word == '0) ? fmt.first_m1 : fmt.other_m1;
            cur.pos    <= (next_word == '0) ? '0 : cur.pos + 1'b1;
            wdata      <= s_valid ? s_data : '0;
        end else if (adv) begin
            cur.bit_i <= cur.bit_i + 1'b1;
            cur.pos   <= cur.pos + 1'b1;
        end
    end

    AST_BIT_IN_WORD: assert property (@(posedge clk) disable iff (rst)
        running |-> (cur.bit_i <= cur.wid_m1)); // R3
    AST_READY_AT_WORD: assert property (@(posedge clk) disable iff (rst)
        (s_ready && !soft_rst) |=> (running && cur.bit_i == '0)); // R6
    AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (s_ready && !s_valid && !soft_rst) |=> (wdata == '0)); // R7

endmodule

// File: rtl/audfrm_flags.sv
module audfrm_flags (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic ws_set,
    input  logic se_set,
    input  logic udr_set,
    input  logic clr_ws,
    input  logic clr_se,
    input  logic clr_udr,
    output logic word_start,
    output logic flag_ws,
    output logic flag_se,
    output logic flag_udr
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            word_start <= 1'b0;
            flag_ws    <= 1'b0;
            flag_se    <= 1'b0;
            flag_udr   <= 1'b0;
        end else begin
            word_start <= ws_set;
            flag_ws    <= ws_set  || (flag_ws  && !clr_ws);
            flag_se    <= se_set  || (flag_se  && !clr_se);
            flag_udr   <= udr_set || (flag_udr && !clr_udr);
        end
    end

    AST_UDR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_udr && !clr_udr && !soft_rst) |=> flag_udr); // R7
    AST_WS_PULSE: assert property (@(posedge clk) disable iff (rst)
        word_start |=> !word_start); // R8

endmodule

// File: rtl/audfrm_tx.sv
module audfrm_tx
    import audfrm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              en,
    input  logic              cfg_bclk_inv,
    input  logic              cfg_msb_first,
    input  logic              cfg_fs_early,
    input  logic              cfg_fs_low,
    input  logic [WRD_IW-1:0] cfg_frame_m1,
    input  logic [BIT_IW-1:0] cfg_sync_m1,
    input  logic [BIT_IW-1:0] cfg_first_m1,
    input  logic [BIT_IW-1:0] cfg_other_m1,
    input  logic [DIV_W-1:0]  cfg_div_m1,
    input  logic              s_valid,
    input  logic [SMP_W-1:0]  s_data,
    output logic              s_ready,
    input  logic              clr_word_start,
    input  logic              clr_sync_err,
    input  logic              clr_underrun,
    output logic              bclk,
    output logic              fsync,
    output logic              sdata,
    output logic              word_start,
    output logic              flag_word_start,
    output logic              flag_sync_err,
    output logic              flag_underrun
);
    fmt_t             fmt;
    cur_t             cur;
    logic             running, ph, tick, go;
    logic             new_word, udr_set, se_set;
    logic [SMP_W-1:0] wdata;

    always_comb begin
        fmt.bclk_inv  = cfg_bclk_inv;
        fmt.msb_first = cfg_msb_first;
        fmt.fs_early  = cfg_fs_early;
        fmt.fs_low    = cfg_fs_low;
        fmt.frame_m1  = cfg_frame_m1;
        fmt.sync_m1   = cfg_sync_m1;
        fmt.first_m1  = cfg_first_m1;
        fmt.other_m1  = cfg_other_m1;
    end

    assign go = running && en && !soft_rst;

    audfrm_clkdiv #(.DIV_W(DIV_W)) div_i (
        .clk(clk), .rst(rst), .go(go), .div_m1(cfg_div_m1), .ph(ph), .tick(tick)
    );

    audfrm_seq seq_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .en(en), .fmt(fmt), .tick(tick),
        .s_valid(s_valid), .s_data(s_data), .running(running), .cur(cur),
        .wdata(wdata), .s_ready(s_ready), .new_word(new_word),
        .udr_set(udr_set), .se_set(se_set)
    );

    audfrm_flags flg_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ws_set(new_word),
        .se_set(se_set), .udr_set(udr_set), .clr_ws(clr_word_start),
        .clr_se(clr_sync_err), .clr_udr(clr_underrun), .word_start(word_start),
        .flag_ws(flag_word_start), .flag_se(flag_sync_err), .flag_udr(flag_underrun)
    );

    always_comb begin
        bclk  = running ? (ph ^ fmt.bclk_inv) : fmt.bclk_inv;
        fsync = running ? (fs_active(fmt, cur) ^ fmt.fs_low) : fmt.fs_low;
        sdata = running ? wdata[bit_sel(fmt.msb_first, cur.wid_m1, cur.bit_i)] : 1'b0;
    end

endmodule

// File: tb/audfrm_tx_tb_top.sv
module audfrm_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1, soft_rst = 1'b0, en = 1'b0;
    logic        inv = 1'b0, msb = 1'b1, early = 1'b0, low = 1'b0;
    logic [3:0]  fr_m1 = '0;
    logic [4:0]  sy_m1 = '0, w0_m1 = '0, wn_m1 = '0;
    logic [7:0]  dv_m1 = '0;
    logic        feed_on = 1'b0;
    logic [31:0] smp [64];
    logic [31:0] ptr = '0;
    logic        s_ready, bclk, fsync, sdata, word_start;
    logic        f_ws, f_se, f_udr;
    logic        c_ws = 1'b0, c_se = 1'b0, c_udr = 1'b0;
    int          checks = 0, fails = 0;

    always #5 clk = ~clk;

    audfrm_tx #(.DIV_W(8)) dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .en(en),
        .cfg_bclk_inv(inv), .cfg_msb_first(msb), .cfg_fs_early(early), .cfg_fs_low(low),
        .cfg_frame_m1(fr_m1), .cfg_sync_m1(sy_m1), .cfg_first_m1(w0_m1),
        .cfg_other_m1(wn_m1), .cfg_div_m1(dv_m1),
        .s_valid(feed_on), .s_data(smp[ptr[5:0]]), .s_ready(s_ready),
        .clr_word_start(c_ws), .clr_sync_err(c_se), .clr_underrun(c_udr),
        .bclk(bclk), .fsync(fsync), .sdata(sdata), .word_start(word_start),
        .flag_word_start(f_ws), .flag_sync_err(f_se), .flag_underrun(f_udr)
    );

    always @(posedge clk) if (feed_on && s_ready) ptr <= ptr + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic exp_bit(input logic [31:0] s, input logic m, input int wm1, input int b);
        return m ? s[wm1 - b] : s[b];
    endfunction

    function automatic logic exp_fs(input logic e, input logic l, input int pos, input int sm1, input logic last);
        logic a;
        a = e ? (last || pos < sm1) : (pos <= sm1);
        return a ^ l;
    endfunction

    task automatic soft_pulse();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    // Runs nfr frames of the given format and compares every bit (R2..R6)
    task automatic run(input int f, input int s, input int a0, input int an,
                       input logic m, input logic e, input logic l, input logic iv,
                       input int d, input int nfr, input logic feed);
        int base, nw, D;
        logic [31:0] sv;
        en = 1'b0;
        soft_pulse();
        fr_m1 = 4'(f); sy_m1 = 5'(s); w0_m1 = 5'(a0); wn_m1 = 5'(an);
        msb = m; early = e; low = l; inv = iv; dv_m1 = 8'(d);
        feed_on = feed; base = ptr; nw = 0; D = d + 1;
        @(negedge clk); en = 1'b1;
        for (int fr = 0; fr < nfr; fr++) begin
            int pos = 0;
            for (int w = 0; w <= f; w++) begin
                int wm1 = (w == 0) ? a0 : an;
                sv = feed ? smp[(base + nw) % 64] : 32'h0;
                for (int b = 0; b <= wm1; b++) begin
                    for (int c = 0; c < 2 * D; c++) begin
                        @(negedge clk);
                        if (c == 0) begin
                            chk(m ? "R4 sdata msb" : "R4 sdata lsb", sdata, exp_bit(sv, m, wm1, b));
                            chk("R5 fsync", fsync,
                                exp_fs(e, l, pos, s, (w == f) && (b == wm1)));
                            chk("R8 word_start", word_start, b == 0);
                            chk("R2 bclk first half", bclk, iv);
                        end
                        if (c == D) chk("R2 bclk second half", bclk, !iv);
                        if (c > 0 && c != D) chk("R2 sdata steady", sdata, exp_bit(sv, m, wm1, b));
                    end
                    pos++;
                end
                nw++;
            end
        end
        en = 1'b0;
        @(negedge clk);
        chk("R6 samples consumed", ptr - base, feed ? nfr * (f + 1) : 0);
        chk("R7 underrun flag", f_udr, !feed);
        chk("R9 no sync error", f_se, 0);
        chk("R8 word start flag", f_ws, 1);
        chk("R1 idle sdata", sdata, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seed = $urandom(32'd1234);
        int t1, t2, n;
        for (int i = 0; i < 64; i++) smp[i] = $urandom();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 bclk", bclk, 0); chk("R1 fsync", fsync, 0); chk("R1 sdata", sdata, 0);
        chk("R1 word_start", word_start, 0); chk("R1 s_ready", s_ready, 0);
        chk("R1 flags", {f_ws, f_se, f_udr}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 flags after reset", {f_ws, f_se, f_udr}, 0);

        run(1, 15, 15, 15, 1, 1, 1, 0, 1, 2, 1);   // stereo, early, active low
        run(1, 15, 15, 15, 1, 0, 0, 0, 0, 2, 1);   // left-justified
        run(1, 0, 15, 15, 1, 1, 0, 0, 1, 2, 1);    // one-bit sync, early
        run(1, 0, 15, 15, 1, 0, 0, 1, 0, 2, 1);    // one-bit sync, late
        run(12, 15, 15, 19, 1, 1, 0, 1, 0, 1, 1);  // thirteen slots, R3
        run(2, 3, 7, 11, 0, 0, 0, 0, 2, 2, 1);     // lsb first, upper bits ignored

        // R8 flag clear
        @(negedge clk); c_ws = 1'b1; @(negedge clk); c_ws = 1'b0;
        chk("R8 word start flag cleared", f_ws, 0);

        // R7 underrun: zeros and sticky flag, then clear
        run(1, 7, 7, 7, 1, 0, 0, 0, 0, 1, 0);
        @(negedge clk);
        chk("R7 flag sticky", f_udr, 1);
        c_udr = 1'b1; @(negedge clk); c_udr = 1'b0;
        chk("R7 flag cleared", f_udr, 0);

        // Random formats
        for (int k = 0; k < 8; k++) begin
            int rf = $urandom_range(3, 0), r0 = $urandom_range(31, 0), rn = $urandom_range(31, 0);
            run(rf, $urandom_range(r0, 0), r0, rn, $urandom_range(1, 0), $urandom_range(1, 0),
                $urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(2, 0), 2, 1);
        end

        // R9 frame size reduced during word 2
        en = 1'b0; soft_pulse();
        fr_m1 = 4'd3; w0_m1 = 5'd3; wn_m1 = 5'd7; sy_m1 = 5'd0; dv_m1 = 8'd0;
        early = 1'b0; low = 1'b0; inv = 1'b0; msb = 1'b1; feed_on = 1'b1;
        @(negedge clk); en = 1'b1;
        t1 = -1; t2 = -1; n = 0;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (c == 30) begin
                chk("R9 no error before change", f_se, 0);
                fr_m1 = 4'd0;
            end
            if (c > 30 && word_start) begin
                if (n == 0) t1 = c; else if (n == 1) t2 = c;
                n++;
            end
        end
        chk("R9 sync error flag", f_se, 1);
        chk("R9 restart at word 0 width", t2 - t1, 8);
        en = 1'b0;
        @(negedge clk); c_se = 1'b1; @(negedge clk); c_se = 1'b0;
        chk("R9 flag cleared", f_se, 0);

        // R10 soft reset during a run
        fr_m1 = 4'd1; w0_m1 = 5'd15; wn_m1 = 5'd15; sy_m1 = 5'd15; low = 1'b1; inv = 1'b1;
        feed_on = 1'b0;
        @(negedge clk); en = 1'b1;
        repeat (21) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        chk("R10 bclk idle", bclk, 1); chk("R10 fsync idle", fsync, 1);
        chk("R10 sdata idle", sdata, 0); chk("R10 flags cleared", {f_ws, f_se, f_udr}, 0);
        soft_rst = 1'b0; en = 1'b0;
        @(negedge clk);
        chk("R10 word_start low", word_start, 0);
        summary();
    end
endmodule